// File: doc/BRIEF.md
# Serial Pause Gate

This block sits between the serial pins of a SPI slave and its command engine and implements an active-low pause input. While the slave is selected, pulling the pause line low freezes the serial sequence where it stands. Clock and data edges stop reaching the engine, and the serial output driver is released. When the pause is lifted, the next clock edge the engine sees is the one that would have followed the last edge before the pause. The engine's bit counters and shift registers therefore carry on without a gap.

All pins are sampled with the system clock through a parameterised synchroniser. Clock edges are found by comparing successive sampled values. The engine receives a one-cycle pulse for each qualified rising edge, which shifts input data in, together with the sampled data bit. It also receives a pulse for each qualified falling edge, which advances output data, and an output enable for the serial data driver.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, and with select high (deselected), shift_pulse and fall_pulse stay low, so_oe is low and paused is low.
- R2: While selected and not paused, every sampled rising edge of sck gives exactly one shift_pulse, with shift_bit equal to si as sampled with that edge. Every sampled falling edge gives exactly one fall_pulse. Both pulses last one cycle.
- R3: A pause begins when hold_n and sck are both sampled low. If hold_n is low while sck is high, the pause begins only once sck is sampled low. The falling edge that ends that bit cell is still passed on as a fall_pulse.
- R4: While paused, any sck or si activity produces no shift_pulse and no fall_pulse.
- R5: A pause ends only on a sampled rising edge of hold_n that occurs while sck is sampled low. A rise of hold_n while sck is high leaves the block paused, even after sck later falls.
- R6: so_oe is high only while selected, with hold_n sampled high and the block not paused. Pulling hold_n low at any time, paused or not, drops so_oe.
- R7: Sampled select high clears the pause within one cycle, suppresses all pulses and drops so_oe. The next selection starts unpaused.
- R8: The sequence of bits delivered by shift_pulse across a pause equals the sequence that would be delivered without the pause. No edge is lost and none is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in pin |
| hold_n | input | 1 | Pause request, active low |
| shift_pulse | output | 1 | One-cycle pulse per qualified sck rising edge |
| shift_bit | output | 1 | Sampled si, valid with shift_pulse |
| fall_pulse | output | 1 | One-cycle pulse per qualified sck falling edge |
| so_oe | output | 1 | Output enable for the serial data driver |
| paused | output | 1 | Pause state |

## Verification
A pin change made at a clock low phase reaches the sampled values after SYNC_STAGES rising edges, two with the default setting. The edge pulses and so_oe follow those sampled values combinationally. The paused flag, and any so_oe change caused by it, settle one edge later. The bench holds each pin pattern for five cycles, counts the pulses seen in that window and checks the settled levels at its end. It also requires so_oe to be low from the third sample onward whenever hold_n is low. This makes every result independent of the exact cycle within the window while still catching missing or doubled edges.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic shift_pulse,
  output logic shift_bit,
  output logic fall_pulse,
  output logic so_oe,
  output logic paused
);
  localparam int PINS = 4;
  localparam logic [PINS-1:0] IDLE = 4'b1001;

  logic [PINS-1:0] sync_q [SYNC_STAGES];
  logic cs_s, sck_s, si_s, hold_s;
  logic sck_p, hold_p, held_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE;
    end else begin
      sync_q[0] <= {cs_n, sck, si, hold_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {cs_s, sck_s, si_s, hold_s} = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= 1'b0;
      hold_p <= 1'b1;
      held_q <= 1'b0;
    end else begin
      sck_p  <= sck_s;
      hold_p <= hold_s;
      if (cs_s)
        held_q <= 1'b0;
      else if (!held_q)
        held_q <= !hold_s && !sck_s;
      else if (hold_s && !hold_p && !sck_s)
        held_q <= 1'b0;
    end
  end

  assign rise        = sck_s && !sck_p;
  assign fall        = !sck_s && sck_p;
  assign shift_pulse = rise && !held_q && !cs_s;
  assign fall_pulse  = fall && !held_q && !cs_s;
  assign shift_bit   = si_s;
  assign so_oe       = !cs_s && hold_s && !held_q;
  assign paused      = held_q;
endmodule

module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sck_s,
  input logic hold_s,
  input logic shift_pulse,
  input logic fall_pulse,
  input logic so_oe,
  input logic paused
);
  // R2
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_pulse && fall_pulse));
  // R3
  entry_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(!sck_s && !hold_s && !cs_s));
  // R4
  no_edge_while_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !shift_pulse && !fall_pulse);
  // R5
  exit_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && !$past(cs_s)) |-> $past(hold_s && !sck_s));
  // R6
  oe_off_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused || !hold_s) |-> !so_oe);
  // R7
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !paused);
endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
  .shift_pulse(shift_pulse), .fall_pulse(fall_pulse), .so_oe(so_oe), .paused(paused)
);

// File: tb/sim_spi_hold_gate.sv
module sim_spi_hold_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic shift_pulse, shift_bit, fall_pulse, so_oe, paused;
  int vectors = 0, fails = 0;
  logic m_held, m_psck, m_phold;
  logic [31:0] acc;

  always #4 clk = ~clk;

  spi_hold_gate u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .shift_pulse(shift_pulse), .shift_bit(shift_bit),
    .fall_pulse(fall_pulse), .so_oe(so_oe), .paused(paused));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_next_held(input logic c, k, h);
    if (c) return 1'b0;
    if (!m_held) return !h && !k;
    if (h && !m_phold && !k) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input logic c, input logic k, input logic d, input logic h);
    int n_sh = 0, n_fa = 0;
    logic bit_got = 1'b0, oe_bad = 1'b0;
    logic e_rise, e_fall, e_held;
    @(negedge clk);
    cs_n = c; sck = k; si = d; hold_n = h;
    e_rise = !c && k && !m_psck && !m_held;
    e_fall = !c && !k && m_psck && !m_held;
    e_held = exp_next_held(c, k, h);
    m_held = e_held; m_psck = k; m_phold = h;
    for (int s = 1; s <= 5; s++) begin
      @(negedge clk);
      if (shift_pulse) begin n_sh++; bit_got = shift_bit; acc = {acc[30:0], shift_bit}; end
      if (fall_pulse) n_fa++;
      if (s >= 3 && !h && so_oe) oe_bad = 1'b1;
    end
    chk(n_sh == int'(e_rise), "R2/R4 shift count", n_sh, int'(e_rise));
    if (e_rise) chk(bit_got == d, "R2 shift bit", int'(bit_got), int'(d));
    chk(n_fa == int'(e_fall), "R2/R3 fall count", n_fa, int'(e_fall));
    chk(paused == e_held, "R3/R5/R7 paused", int'(paused), int'(e_held));
    chk(so_oe == (!c && h && !e_held), "R6 so_oe", int'(so_oe), int'(!c && h && !e_held));
    chk(!oe_bad, "R6 so_oe during hold low", int'(oe_bad), 0);
  endtask

  task automatic send_bit(input logic d);
    step(1'b0, 1'b0, d, 1'b1);
    step(1'b0, 1'b1, d, 1'b1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] word;
    m_held = 1'b0; m_psck = 1'b0; m_phold = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!so_oe && !paused && !shift_pulse && !fall_pulse, "R1 idle", int'(so_oe), 0);

    // R8: pause in the middle of an address word, sck toggles during pause
    word = 16'hA5C3; acc = '0;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 15; i >= 0; i--) begin
      send_bit(word[i]);
      if (i == 9) begin
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        for (int t = 0; t < 4; t++) step(1'b0, t[0] ? 1'b0 : 1'b1, t[1], 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
      end
    end
    chk(acc[15:0] == word, "R8 bits across pause", int'(acc[15:0]), int'(word));

    // R3: hold low while sck high defers entry; falling edge still delivered
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk(!paused, "R3 deferred entry", int'(paused), 0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    // R5: hold rise with sck high does not resume
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(paused, "R5 no resume with sck high", int'(paused), 1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(!paused, "R5 resume with sck low", int'(paused), 0);

    // R8: pause in read data, deferred entry mid bit cell
    word = 16'h3C96; acc = '0;
    for (int i = 15; i >= 0; i--) begin
      if (i == 4) begin
        step(1'b0, 1'b0, word[i], 1'b1);
        step(1'b0, 1'b1, word[i], 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
      end else send_bit(word[i]);
    end
    chk(acc[15:0] == word, "R8 read data across pause", int'(acc[15:0]), int'(word));

    // R7: deselect while paused clears the pause
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(!paused && !so_oe, "R7 deselect clears", int'(paused), 0);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk(!paused && so_oe, "R7 fresh select", int'(so_oe), 1);

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic c, k, d, h;
      c = ($urandom % 20) == 0;
      h = ($urandom % 5) != 0;
      k = (($urandom % 10) < 6) ? !m_psck : m_psck;
      d = $urandom % 2;
      step(c, k, d, h);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule